// File: doc/BRIEF.md
# Receive Sampling Tap Sweep Sequencer

This block searches for the best receive sampling delay of a memory-card interface. When started in a timing mode that needs it, it walks a tap value upward from 0 and loads each tap into the delay line. A tap is only loaded once the line's update handshake has been completed twice in a row. It then asks an external pattern checker whether a test transfer at that tap succeeded. It keeps track of the longest unbroken run of passing taps, and at the end loads the tap in the middle of that run. If no tap passes, it flags an error instead.

A controller drives `start_i` together with the current timing mode and waits for `done_o`. After `done_o`, `error_o` shows whether the sweep found a window. `tune_val_o` holds the value that was loaded last.

States: IDLE (waiting for a start), LOAD (one-cycle load strobe), WAIT (waiting for the update acknowledge, with a timeout), TEST (test request held until the response), SCORE (update the streak with the tap's result), PICK (choose the centre of the best run or flag an error), DONE (one-cycle completion pulse).

Transitions:
- IDLE→LOAD on a start in a tuning mode, and IDLE→DONE on a start in any other mode.
- LOAD→WAIT always.
- From WAIT:
  - WAIT→LOAD after the first acknowledge.
  - WAIT→TEST after the second acknowledge of a sweep tap.
  - WAIT→DONE after the second acknowledge of the final value, or on a timeout during the final load.
  - WAIT→SCORE on a timeout during a sweep tap.
- TEST→SCORE on a response.
- SCORE→LOAD for the next tap, and SCORE→PICK after the last tap.
- PICK→LOAD when a window exists, and PICK→DONE when none does.
- DONE→IDLE always.

Top module: `tune_sweep_engine`

## Requirements
- R1: A sweep loads the tap values 0, 1, …, TAP_COUNT-1 (default 40) in ascending order. `tune_val_o` never reaches TAP_COUNT, even though it is 6 bits wide.
- R2: A failing tap sets the current run length to zero. A passing tap lengthens it by one. A run replaces the recorded best only when it is strictly longer, so of two equal runs the earlier one is kept.
- R3: The final value is the last tap of the best run minus half the best run length, rounded down. It is loaded after the sweep and remains on `tune_val_o`.
- R4: When no tap passes, `error_o` is set, `done_o` pulses, and no final value is loaded.
- R5: Each load of a value is a one-cycle `tune_load_o` pulse followed by a wait for `tune_ack_i`. This is done twice with the same value, both for sweep taps and for the final value.
- R6: A sweep runs only when `mode_i` is 3'd4 (HS200) or 3'd5 (SDR104). For any other code, `done_o` pulses in the cycle after the start is sampled, with no load and no test request.
- R7: If `tune_ack_i` is not seen within 16 cycles after a load pulse, the load times out. During the sweep, that tap counts as failing, its test request is skipped, and after a timeout on the first load the second load is also skipped. During the final load, a timeout sets `error_o`.
- R8: `done_o` is a one-cycle pulse. `busy_o` is high from an accepted start until `done_o`. `error_o` holds its value until the next accepted start.
- R9: `test_req_o` stays high until `test_rsp_i`. `test_pass_i` is taken in the same cycle as `test_rsp_i`. There is one request per tap whose two loads both completed.
- R10: After reset, all outputs are zero.
- R11: A start while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled in IDLE |
| mode_i | input | 3 | Timing mode code; 4 and 5 request a sweep |
| tune_ack_i | input | 1 | Delay line has cleared its update request |
| test_rsp_i | input | 1 | Pattern checker response valid |
| test_pass_i | input | 1 | Pattern checker verdict, valid with `test_rsp_i` |
| tune_val_o | output | 6 | Tap value presented to the delay line |
| tune_load_o | output | 1 | One-cycle load strobe |
| test_req_o | output | 1 | Test transfer request |
| done_o | output | 1 | Completion pulse |
| error_o | output | 1 | No passing window, or final load timed out |
| busy_o | output | 1 | Sequence in progress |

## Verification
The sweep is run against several pass masks:
- All taps pass, a single interior window, and a lone pass at tap 0 or tap 39. These check the centre arithmetic, including rounding and the end taps.
- Two equal windows. This shows that ties keep the earlier window.
- A short window followed by a longer one. This shows that a later run replaces the best only when it is strictly longer.
- No passing tap at all. This separates the error path from the final load.

Stalled acknowledges on a first load, on a second load and on the final load check that a timeout splits a window and changes the chosen centre. Non-tuning mode codes and a start during a sweep check that neither one changes the sequence of load strobes.

// File: rtl/tune_pkg.sv
package tune_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_TEST,
        ST_SCORE,
        ST_PICK,
        ST_DONE
    } tune_state_t;

    localparam logic [2:0] MODE_HS200  = 3'd4;
    localparam logic [2:0] MODE_SDR104 = 3'd5;

    function automatic logic mode_needs_sweep(input logic [2:0] m);
        return (m == MODE_HS200) || (m == MODE_SDR104);
    endfunction

endpackage

// File: rtl/tune_ack_timer.sv
module tune_ack_timer #(
    parameter int ACK_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = (ACK_LIMIT > 1) ? $clog2(ACK_LIMIT) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == CNT_W'(ACK_LIMIT - 1));

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !expired_o) |=> (cnt_q != '0 || clr_i)); // R7

endmodule

// File: rtl/tune_streak_tracker.sv
module tune_streak_tracker #(
    parameter int TAP_W = 6,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             score_i,
    input  logic             pass_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic [LEN_W-1:0] best_len_o,
    output logic [TAP_W-1:0] best_end_o
);
    logic [LEN_W-1:0] run_q;
    logic [LEN_W-1:0] best_q;
    logic [TAP_W-1:0] end_q;
    logic [LEN_W-1:0] run_inc;

    assign run_inc = run_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (clear_i) begin
            run_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (score_i) begin
            if (pass_i) begin
                run_q <= run_inc;
                if (run_inc > best_q) begin
                    best_q <= run_inc;
                    end_q  <= tap_i;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign best_len_o = best_q;
    assign best_end_o = end_q;

    AST_BEST_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (score_i && !clear_i) |=> (best_q >= $past(best_q))); // R2
    AST_FAIL_ZEROES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (score_i && !pass_i && !clear_i) |=> (run_q == '0)); // R2
    AST_RUN_NOT_ABOVE_BEST: assert property (@(posedge clk) disable iff (!rst_n)
        score_i |=> (run_q <= best_q)); // R2

endmodule

// File: rtl/tune_sweep_fsm.sv
module tune_sweep_fsm
    import tune_pkg::*;
#(
    parameter int TAP_W     = 6,
    parameter int TAP_COUNT = 40,
    parameter int LEN_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       mode_i,
    input  logic             tune_ack_i,
    input  logic             test_rsp_i,
    input  logic             test_pass_i,
    input  logic             timer_expired_i,
    input  logic [LEN_W-1:0] best_len_i,
    input  logic [TAP_W-1:0] best_end_i,
    output logic [TAP_W-1:0] tune_val_o,
    output logic             tune_load_o,
    output logic             test_req_o,
    output logic             done_o,
    output logic             error_o,
    output logic             busy_o,
    output logic             timer_clr_o,
    output logic             timer_run_o,
    output logic             trk_clear_o,
    output logic             trk_score_o,
    output logic             trk_pass_o,
    output logic [TAP_W-1:0] trk_tap_o
);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAP_COUNT - 1);

    tune_state_t      state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] final_q;
    logic             final_phase_q;
    logic             second_q;
    logic             tap_ok_q;
    logic             err_q;
    logic             start_sweep;
    logic             start_skip;

    assign start_sweep = (state_q == ST_IDLE) && start_i && mode_needs_sweep(mode_i);
    assign start_skip  = (state_q == ST_IDLE) && start_i && !mode_needs_sweep(mode_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_sweep)     state_d = ST_LOAD;
                else if (start_skip) state_d = ST_DONE;
            end
            ST_LOAD: state_d = ST_WAIT;
            ST_WAIT: begin
                if (tune_ack_i) begin
                    if (!second_q)          state_d = ST_LOAD;
                    else if (final_phase_q) state_d = ST_DONE;
                    else                    state_d = ST_TEST;
                end else if (timer_expired_i) begin
                    state_d = final_phase_q ? ST_DONE : ST_SCORE;
                end
            end
            ST_TEST: begin
                if (test_rsp_i) state_d = ST_SCORE;
            end
            ST_SCORE: state_d = (tap_q == LAST_TAP) ? ST_PICK : ST_LOAD;
            ST_PICK:  state_d = (best_len_i == '0) ? ST_DONE : ST_LOAD;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q         <= '0;
            final_q       <= '0;
            final_phase_q <= 1'b0;
            second_q      <= 1'b0;
            tap_ok_q      <= 1'b0;
            err_q         <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        tap_q         <= '0;
                        final_phase_q <= 1'b0;
                        second_q      <= 1'b0;
                        err_q         <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (tune_ack_i) begin
                        second_q <= !second_q;
                        tap_ok_q <= 1'b0;
                    end else if (timer_expired_i) begin
                        second_q <= 1'b0;
                        tap_ok_q <= 1'b0;
                        if (final_phase_q) err_q <= 1'b1;
                    end
                end
                ST_TEST: begin
                    if (test_rsp_i) tap_ok_q <= test_pass_i;
                end
                ST_SCORE: begin
                    if (tap_q != LAST_TAP) tap_q <= tap_q + 1'b1;
                end
                ST_PICK: begin
                    if (best_len_i == '0) begin
                        err_q <= 1'b1;
                    end else begin
                        final_q       <= best_end_i - TAP_W'(best_len_i >> 1);
                        final_phase_q <= 1'b1;
                        second_q      <= 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tune_val_o  = final_phase_q ? final_q : tap_q;
        tune_load_o = (state_q == ST_LOAD);
        test_req_o  = (state_q == ST_TEST);
        done_o      = (state_q == ST_DONE);
        busy_o      = (state_q != ST_IDLE);
        error_o     = err_q;
        timer_clr_o = (state_q == ST_LOAD);
        timer_run_o = (state_q == ST_WAIT) && !tune_ack_i;
        trk_clear_o = start_sweep;
        trk_score_o = (state_q == ST_SCORE);
        trk_pass_o  = tap_ok_q;
        trk_tap_o   = tap_q;
    end

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tune_load_o |=> !tune_load_o); // R5
    AST_LOAD_VALUE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && tune_ack_i && !second_q) |=> (tune_load_o && $stable(tune_val_o))); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req_o && !test_rsp_i) |=> test_req_o); // R9
    AST_SKIP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        start_skip |=> (done_o && !error_o)); // R6
    AST_TAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tune_val_o <= LAST_TAP); // R1
    AST_TIMEOUT_NO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_expired_i && !tune_ack_i && !final_phase_q) |=> !test_req_o); // R7

endmodule

// File: rtl/tune_sweep_engine.sv
module tune_sweep_engine #(
    parameter int TAP_W     = 6,
    parameter int TAP_COUNT = 40,
    parameter int ACK_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       mode_i,
    input  logic             tune_ack_i,
    input  logic             test_rsp_i,
    input  logic             test_pass_i,
    output logic [TAP_W-1:0] tune_val_o,
    output logic             tune_load_o,
    output logic             test_req_o,
    output logic             done_o,
    output logic             error_o,
    output logic             busy_o
);
    localparam int LEN_W = $clog2(TAP_COUNT + 1);

    logic             timer_clr;
    logic             timer_run;
    logic             timer_expired;
    logic             trk_clear;
    logic             trk_score;
    logic             trk_pass;
    logic [TAP_W-1:0] trk_tap;
    logic [LEN_W-1:0] best_len;
    logic [TAP_W-1:0] best_end;

    tune_sweep_fsm #(
        .TAP_W     (TAP_W),
        .TAP_COUNT (TAP_COUNT),
        .LEN_W     (LEN_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .mode_i          (mode_i),
        .tune_ack_i      (tune_ack_i),
        .test_rsp_i      (test_rsp_i),
        .test_pass_i     (test_pass_i),
        .timer_expired_i (timer_expired),
        .best_len_i      (best_len),
        .best_end_i      (best_end),
        .tune_val_o      (tune_val_o),
        .tune_load_o     (tune_load_o),
        .test_req_o      (test_req_o),
        .done_o          (done_o),
        .error_o         (error_o),
        .busy_o          (busy_o),
        .timer_clr_o     (timer_clr),
        .timer_run_o     (timer_run),
        .trk_clear_o     (trk_clear),
        .trk_score_o     (trk_score),
        .trk_pass_o      (trk_pass),
        .trk_tap_o       (trk_tap)
    );

    tune_ack_timer #(
        .ACK_LIMIT (ACK_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (timer_clr),
        .run_i     (timer_run),
        .expired_o (timer_expired)
    );

    tune_streak_tracker #(
        .TAP_W (TAP_W),
        .LEN_W (LEN_W)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (trk_clear),
        .score_i    (trk_score),
        .pass_i     (trk_pass),
        .tap_i      (trk_tap),
        .best_len_o (best_len),
        .best_end_o (best_end)
    );

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R8
    AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(error_o)); // R8

endmodule

// File: tb/tune_sweep_engine_tb_top.sv
module tune_sweep_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic       tune_ack_i = 1'b0;
    logic       test_rsp_i = 1'b0;
    logic       test_pass_i = 1'b0;
    logic [5:0] tune_val_o;
    logic       tune_load_o;
    logic       test_req_o;
    logic       done_o;
    logic       error_o;
    logic       busy_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference model state
    int  exp_val[$];
    bit  exp_ack[$];
    bit  exp_pass[$];
    int  ack_dly = 1;
    int  rsp_dly = 0;
    int  ack_cnt = 0;
    int  rsp_cnt = 0;
    bit  req_open = 1'b0;
    bit  cur_pass = 1'b0;
    bit  prev_load = 1'b0;

    always #4 clk = ~clk;

    tune_sweep_engine dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .tune_ack_i  (tune_ack_i),
        .test_rsp_i  (test_rsp_i),
        .test_pass_i (test_pass_i),
        .tune_val_o  (tune_val_o),
        .tune_load_o (tune_load_o),
        .test_req_o  (test_req_o),
        .done_o      (done_o),
        .error_o     (error_o),
        .busy_o      (busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // delay line and pattern checker models, compared against expectations each clock
    always @(negedge clk) begin
        cyc++;
        if (ack_cnt > 0) begin
            ack_cnt--;
            tune_ack_i = (ack_cnt == 0);
        end else begin
            tune_ack_i = 1'b0;
        end
        if (tune_load_o) begin
            chk(!prev_load, "R5", 1, 0, "load strobe longer than one cycle");
            if (exp_val.size() == 0) begin
                chk(1'b0, "R1", int'(tune_val_o), -1, "unexpected load");
            end else begin
                int v;
                bit a;
                v = exp_val.pop_front();
                a = exp_ack.pop_front();
                chk(int'(tune_val_o) == v, "R1", int'(tune_val_o), v, "loaded tap value");
                if (a) ack_cnt = ack_dly;
            end
        end
        prev_load = tune_load_o;
        if (test_rsp_i) begin
            test_rsp_i = 1'b0;
        end else if (test_req_o) begin
            if (!req_open) begin
                req_open = 1'b1;
                rsp_cnt = rsp_dly;
                if (exp_pass.size() == 0) begin
                    chk(1'b0, "R9", 1, 0, "unexpected test request");
                    cur_pass = 1'b0;
                end else begin
                    cur_pass = exp_pass.pop_front();
                end
            end
            if (rsp_cnt == 0) begin
                test_rsp_i = 1'b1;
                test_pass_i = cur_pass;
                req_open = 1'b0;
            end else begin
                rsp_cnt--;
            end
        end
    end

    function automatic bit [63:0] span(input int lo, input int hi);
        bit [63:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    task automatic run_sweep(input string name, input bit [63:0] mask, input bit [63:0] stall1,
                             input bit [63:0] stall2, input bit final_stall,
                             input int adly, input int rdly, input bit poke);
        int cur = 0;
        int best = 0;
        int endt = 0;
        int fin = 0;
        bit xerr;
        int waited = 0;
        ack_dly = adly;
        rsp_dly = rdly;
        for (int t = 0; t < 40; t++) begin
            bit ok;
            ok = 1'b0;
            exp_val.push_back(t);
            exp_ack.push_back(!stall1[t]);
            if (!stall1[t]) begin
                exp_val.push_back(t);
                exp_ack.push_back(!stall2[t]);
                if (!stall2[t]) begin
                    exp_pass.push_back(mask[t]);
                    ok = mask[t];
                end
            end
            if (ok) begin
                cur++;
                if (cur > best) begin
                    best = cur;
                    endt = t;
                end
            end else begin
                cur = 0;
            end
        end
        xerr = (best == 0);
        if (!xerr) begin
            fin = endt - best / 2;
            exp_val.push_back(fin);
            exp_ack.push_back(!final_stall);
            if (!final_stall) begin
                exp_val.push_back(fin);
                exp_ack.push_back(1'b1);
            end else begin
                xerr = 1'b1;
            end
        end
        @(negedge clk);
        start_i = 1'b1;
        mode_i = 3'd4;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8", int'(busy_o), 1, {name, " busy after start"});
        while (!done_o && waited < 5000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 200) begin
                start_i = 1'b1;
                mode_i = 3'd0;
            end else begin
                start_i = 1'b0;
            end
        end
        chk(done_o == 1'b1, "R8", int'(done_o), 1, {name, " done reached"});
        chk(exp_val.size() == 0, "R5", exp_val.size(), 0, {name, " loads left over"});
        chk(exp_pass.size() == 0, "R9", exp_pass.size(), 0, {name, " test requests left over"});
        chk(error_o == xerr, "R4", int'(error_o), int'(xerr), {name, " error flag"});
        if (!xerr) chk(int'(tune_val_o) == fin, "R3", int'(tune_val_o), fin, {name, " final tap"});
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R8", int'(done_o), 0, {name, " done single cycle"});
        chk(error_o == xerr, "R8", int'(error_o), int'(xerr), {name, " error held"});
        exp_val.delete();
        exp_ack.delete();
        exp_pass.delete();
    endtask

    task automatic run_skip(input logic [2:0] m);
        @(negedge clk);
        start_i = 1'b1;
        mode_i = m;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b1, "R6", int'(done_o), 1, "done one cycle after start in non-tuning mode");
        chk(error_o == 1'b0, "R6", int'(error_o), 0, "no error in non-tuning mode");
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R6", int'(busy_o), 0, "idle after skip");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tune_load_o == 0 && test_req_o == 0 && done_o == 0 && error_o == 0 &&
            busy_o == 0 && tune_val_o == 0, "R10", int'(busy_o), 0, "reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && tune_val_o == 0, "R10", int'(tune_val_o), 0, "idle after reset");

        run_skip(3'd0);
        run_skip(3'd2);
        run_skip(3'd6);
        run_sweep("all pass", span(0, 39), '0, '0, 1'b0, 1, 0, 1'b0);           // R3: 39-20
        run_sweep("mid window", span(10, 19), '0, '0, 1'b0, 2, 1, 1'b0);        // R3: 14
        run_sweep("tie", span(3, 7) | span(20, 24), '0, '0, 1'b0, 1, 0, 1'b0);   // R2: earlier kept, 5
        run_sweep("longer later", span(2, 4) | span(30, 37), '0, '0, 1'b0, 3, 2, 1'b0); // R2: 33
        run_sweep("none", '0, '0, '0, 1'b0, 1, 0, 1'b0);                         // R4
        run_sweep("no pass after error", span(0, 0), '0, '0, 1'b0, 1, 0, 1'b0);   // R3: 0, error cleared
        run_sweep("last only", span(39, 39), '0, '0, 1'b0, 1, 0, 1'b0);           // R1: 39
        run_sweep("stall splits", span(0, 39), span(15, 15), span(5, 5), 1'b0, 1, 0, 1'b0); // R7: 27
        run_sweep("final stall", span(8, 11), '0, '0, 1'b1, 1, 0, 1'b0);         // R7: error
        run_sweep("start ignored", span(20, 29), '0, '0, 1'b0, 2, 0, 1'b1);      // R11
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 190000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule